// File: doc/BRIEF.md
# Exception Entry Controller

This block carries out the processor state changes needed to take an interrupt request (IRQ) or a prefetch abort. The core presents its current status word, the address of the instruction now executing, the request lines and a select for the high vector base. A strobe marks each instruction boundary. When a request is accepted at a boundary, the block commands the register file to switch into the exception's mode. It supplies the new link register value, the old status word to be saved into the banked saved-status register, and the new status word. That new word has the Thumb bit cleared and the IRQ mask set. The block also clears any wait-for-interrupt halt. One cycle later it redirects fetch to the exception vector.

While the status word's IRQ mask bit is set, every request is refused. This covers prefetch aborts as well as IRQs, and no state changes. A separate flag-only IRQ input latches a pending interrupt when it is unmasked and wakes the core. The pending interrupt is then taken at the next boundary, even with the IRQ line low. When an abort and an IRQ arrive together, the abort goes first and the IRQ is kept pending.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, entry_we_o, redirect_o, both acknowledges, wfi_clr_o and irq_pending_o are all low.
- R2: While status bit 7 (the IRQ mask) is set, no request or flag is accepted. There is no write strobe, no acknowledge, no wake, and irq_pending_o keeps its value.
- R3: An unmasked IRQ sampled with boundary_i high gives, in the next cycle, entry_we_o and irq_ack_o high with mode_o = 5'b10010.
- R4: An unmasked prefetch abort sampled with boundary_i high gives, in the next cycle, entry_we_o and pabt_ack_o high with mode_o = 5'b10111.
- R5: In the entry cycle, lr_data_o equals the current instruction address sampled at acceptance plus 4, modulo 2^32.
- R6: In the entry cycle, spsr_data_o equals the status word exactly as sampled at acceptance.
- R7: In the entry cycle, status_data_o is the old status word with bit 5 (Thumb) cleared, bit 7 (IRQ mask) set and bits 4:0 replaced by the new mode. All other bits are kept.
- R8: The redirect address is base + 0x18 for an IRQ and base + 0x0C for an abort. The base is 0xFFFF0000 if hi_vec_i was high at acceptance, otherwise 0.
- R9: Entry takes two cycles. The writes come in the first cycle and redirect_o in the second. Requests held during those two cycles are not accepted, so a held request is accepted again three cycles after the previous acceptance.
- R10: wfi_clr_o is high for one cycle in every entry cycle. It is also high in the cycle after an unmasked flag-only request.
- R11: An unmasked flag-only request sets irq_pending_o in the next cycle. A later boundary then takes an IRQ with irq_req_i low, and irq_pending_o is low in the entry cycle.
- R12: When the IRQ and abort requests are accepted together, the abort is taken and irq_pending_o is high afterwards.
- R13: With boundary_i low, no IRQ or abort request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 32 | Current status word (mode 4:0, Thumb 5, IRQ mask 7) |
| cur_pc_i | input | 32 | Address of the instruction now executing |
| boundary_i | input | 1 | Instruction boundary; requests are sampled only here |
| irq_req_i | input | 1 | IRQ request line |
| pabt_req_i | input | 1 | Prefetch-abort request |
| irq_flag_i | input | 1 | Flag-only IRQ: wake and latch pending |
| hi_vec_i | input | 1 | Select the high vector base |
| entry_we_o | output | 1 | Mode switch, link and saved-status write strobe |
| mode_o | output | 5 | Mode to switch into |
| lr_data_o | output | 32 | Link register value |
| spsr_data_o | output | 32 | Old status word for the saved-status register |
| status_data_o | output | 32 | New status word |
| wfi_clr_o | output | 1 | Clear wait-for-interrupt halt |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_addr_o | output | 32 | Vector address (zero when not redirecting) |
| irq_ack_o | output | 1 | IRQ entry in progress |
| pabt_ack_o | output | 1 | Abort entry in progress |
| irq_pending_o | output | 1 | Latched pending IRQ |

## Verification
The hardest situation to reach is a pending IRQ that has to survive a masked stretch. It is created either by an abort colliding with an IRQ or by a flag-only request. It must then be taken later with no request line active. The sweep reaches it by firing simultaneous requests while walking the mask, Thumb bit and vector select through every combination. A bench model of the pending latch predicts when the deferred IRQ surfaces. Held requests with a permanently asserted boundary exercise the three-cycle spacing of back-to-back entries.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int MODE_W = 5;
  localparam int I_POS  = 7;
  localparam int T_POS  = 5;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ENTER, SEQ_REDIR} seq_e;
  typedef enum logic {KIND_IRQ, KIND_PABT} kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic boundary_i,
  input  logic mask_i,
  input  logic irq_req_i,
  input  logic pabt_req_i,
  input  logic irq_flag_i,
  output logic take_irq_o,
  output logic take_pabt_o,
  output logic flag_ok_o,
  output logic pend_o
);
  logic pend_q, pend_d, at_slot, defer_irq;

  // a request is only considered at a boundary, while idle and unmasked
  assign at_slot     = idle_i && boundary_i && !mask_i;
  assign take_pabt_o = at_slot && pabt_req_i;
  assign take_irq_o  = at_slot && !pabt_req_i && (irq_req_i || pend_q);
  assign flag_ok_o   = irq_flag_i && !mask_i;
  assign defer_irq   = take_pabt_o && irq_req_i;

  always_comb begin
    pend_d = pend_q || flag_ok_o || defer_irq;
    if (take_irq_o) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  a_r11_flag_latches: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ok_o && !take_irq_o |=> pend_q);
  a_r2_mask_holds_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> $stable(pend_q));
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_entry_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_irq_i,
  input  logic  take_pabt_i,
  input  logic  flag_ok_i,
  output logic  idle_o,
  output logic  enter_o,
  output logic  redir_o,
  output kind_e kind_o,
  output logic  wfi_clr_o
);
  seq_e  state_q, state_d;
  kind_e kind_q;
  logic  wfi_q, take_any;

  assign take_any = take_irq_i || take_pabt_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (take_any) state_d = SEQ_ENTER;
      SEQ_ENTER: state_d = SEQ_REDIR;
      SEQ_REDIR: state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      kind_q  <= KIND_IRQ;
      wfi_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_any) kind_q <= take_pabt_i ? KIND_PABT : KIND_IRQ;
      wfi_q   <= take_any || flag_ok_i;
    end
  end

  assign idle_o    = (state_q == SEQ_IDLE);
  assign enter_o   = (state_q == SEQ_ENTER);
  assign redir_o   = (state_q == SEQ_REDIR);
  assign kind_o    = kind_q;
  assign wfi_clr_o = wfi_q;

  a_r9_take_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_o |-> !take_any);
  a_r10_wake_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> wfi_clr_o);
endmodule

// File: rtl/exc_frame.sv
module exc_frame
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 32,
  parameter logic [AW-1:0] VEC_HI_BASE = AW'(32'hFFFF0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  kind_e             kind_i,
  input  logic [SW-1:0]     status_i,
  input  logic [AW-1:0]     cur_pc_i,
  input  logic              hi_vec_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [AW-1:0]     lr_o,
  output logic [SW-1:0]     spsr_o,
  output logic [SW-1:0]     status_new_o,
  output logic [AW-1:0]     vec_o
);
  localparam logic [AW-1:0] OFS_IRQ  = AW'(24);
  localparam logic [AW-1:0] OFS_PABT = AW'(12);
  localparam logic [AW-1:0] LINK_OFS = AW'(4);

  logic [SW-1:0] old_q;
  logic [AW-1:0] pc_q;
  logic          hi_q;

  function automatic logic [AW-1:0] link_of(input logic [AW-1:0] pc);
    return pc + LINK_OFS;
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(input kind_e k);
    return (k == KIND_PABT) ? MODE_ABT : MODE_IRQ;
  endfunction

  function automatic logic [SW-1:0] entered(input logic [SW-1:0] old,
                                            input logic [MODE_W-1:0] m);
    logic [SW-1:0] s;
    s = old;
    s[I_POS] = 1'b1;
    s[T_POS] = 1'b0;
    s[MODE_W-1:0] = m;
    return s;
  endfunction

  function automatic logic [AW-1:0] vector_of(input logic hi, input kind_e k);
    logic [AW-1:0] base;
    base = hi ? VEC_HI_BASE : '0;
    return base + ((k == KIND_PABT) ? OFS_PABT : OFS_IRQ);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
      pc_q  <= '0;
      hi_q  <= 1'b0;
    end else if (capture_i) begin
      old_q <= status_i;
      pc_q  <= cur_pc_i;
      hi_q  <= hi_vec_i;
    end
  end

  assign mode_o       = mode_of(kind_i);
  assign lr_o         = link_of(pc_q);
  assign spsr_o       = old_q;
  assign status_new_o = entered(old_q, mode_o);
  assign vec_o        = vector_of(hi_q, kind_i);

  a_r6_saved_status: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> spsr_o == $past(status_i));
  a_r5_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> lr_o == $past(cur_pc_i) + LINK_OFS);
  a_r7_new_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> status_new_o[I_POS] && !status_new_o[T_POS]
                  && (status_new_o[MODE_W-1:0] == mode_o));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     status_i,
  input  logic [AW-1:0]     cur_pc_i,
  input  logic              boundary_i,
  input  logic              irq_req_i,
  input  logic              pabt_req_i,
  input  logic              irq_flag_i,
  input  logic              hi_vec_i,
  output logic              entry_we_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [AW-1:0]     lr_data_o,
  output logic [SW-1:0]     spsr_data_o,
  output logic [SW-1:0]     status_data_o,
  output logic              wfi_clr_o,
  output logic              redirect_o,
  output logic [AW-1:0]     redirect_addr_o,
  output logic              irq_ack_o,
  output logic              pabt_ack_o,
  output logic              irq_pending_o
);
  logic  idle, enter, redir, take_irq, take_pabt, flag_ok, capture;
  kind_e kind;
  logic [AW-1:0] vec;

  exc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .boundary_i(boundary_i),
    .mask_i(status_i[I_POS]), .irq_req_i(irq_req_i), .pabt_req_i(pabt_req_i),
    .irq_flag_i(irq_flag_i), .take_irq_o(take_irq), .take_pabt_o(take_pabt),
    .flag_ok_o(flag_ok), .pend_o(irq_pending_o)
  );

  exc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .take_irq_i(take_irq), .take_pabt_i(take_pabt),
    .flag_ok_i(flag_ok), .idle_o(idle), .enter_o(enter), .redir_o(redir),
    .kind_o(kind), .wfi_clr_o(wfi_clr_o)
  );

  assign capture = take_irq || take_pabt;

  exc_frame #(.AW(AW), .SW(SW)) u_frame (
    .clk(clk), .rst_n(rst_n), .capture_i(capture), .kind_i(kind),
    .status_i(status_i), .cur_pc_i(cur_pc_i), .hi_vec_i(hi_vec_i),
    .mode_o(mode_o), .lr_o(lr_data_o), .spsr_o(spsr_data_o),
    .status_new_o(status_data_o), .vec_o(vec)
  );

  assign entry_we_o      = enter;
  assign redirect_o      = redir;
  assign redirect_addr_o = redir ? vec : '0;
  assign irq_ack_o       = enter && (kind == KIND_IRQ);
  assign pabt_ack_o      = enter && (kind == KIND_PABT);

  a_r2_masked_refused: assert property (@(posedge clk) disable iff (!rst_n)
    status_i[I_POS] |=> !entry_we_o);
  a_r13_no_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> !entry_we_o);
  a_r9_redirect_follows: assert property (@(posedge clk) disable iff (!rst_n)
    entry_we_o |=> redirect_o && !entry_we_o);
  a_r3_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack_o, pabt_ack_o}));
  a_r12_irq_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    take_pabt && irq_req_i |=> irq_pending_o && pabt_ack_o);
  a_r11_pending_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> !irq_pending_o);
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] status_i = '0, cur_pc_i = '0;
  logic boundary_i = 0, irq_req_i = 0, pabt_req_i = 0, irq_flag_i = 0, hi_vec_i = 0;
  logic entry_we_o, wfi_clr_o, redirect_o, irq_ack_o, pabt_ack_o, irq_pending_o;
  logic [4:0] mode_o;
  logic [31:0] lr_data_o, spsr_data_o, status_data_o, redirect_addr_o;
  int checks = 0, errors = 0;
  bit pend_m = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl dut (.*);

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, a, e);
    end
  endtask

  // one boundary with the given stimulus, then entry and redirect cycles
  task automatic attempt(input logic [31:0] st, input logic [31:0] pc, input bit hi,
                         input bit irq, input bit pabt);
    bit take, tk_pabt;
    logic [4:0] md;
    take = !st[7] && (irq || pabt || pend_m);
    tk_pabt = take && pabt;
    md = tk_pabt ? 5'h17 : 5'h12;
    status_i = st; cur_pc_i = pc; hi_vec_i = hi;
    irq_req_i = irq; pabt_req_i = pabt; boundary_i = 1;
    @(negedge clk);
    boundary_i = 0; irq_req_i = 0; pabt_req_i = 0;
    status_i = ~st | 32'h80; cur_pc_i = ~pc; hi_vec_i = ~hi;
    if (take) pend_m = tk_pabt && irq;
    chk(st[7] ? "R2 refused" : "R3/R4 entry strobe", entry_we_o, take);
    chk("R3 irq ack", irq_ack_o, take && !tk_pabt);
    chk("R4 pabt ack", pabt_ack_o, tk_pabt);
    chk("R10 wake", wfi_clr_o, take);
    chk("R12/R11 pending", irq_pending_o, pend_m);
    if (take) begin
      chk("R3/R4 mode", mode_o, md);
      chk("R5 link", lr_data_o, pc + 32'd4);
      chk("R6 saved status", spsr_data_o, st);
      chk("R7 new status", status_data_o, (st & 32'hFFFF_FF40) | 32'h80 | md);
    end
    @(negedge clk);
    chk("R9 redirect", redirect_o, take);
    chk("R9 no second write", entry_we_o, 0);
    if (take)
      chk("R8 vector", redirect_addr_o,
          (hi ? 32'hFFFF_0000 : 32'h0) + (tk_pabt ? 32'hC : 32'h18));
    @(negedge clk);
    chk("R9 back to idle", redirect_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] pcs [3];
    pcs[0] = 32'h0; pcs[1] = 32'h0000_8124; pcs[2] = 32'hFFFF_FFFC;
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", entry_we_o, 0);
    chk("R1 reset redirect", redirect_o, 0);
    chk("R1 reset acks", {irq_ack_o, pabt_ack_o}, 0);
    chk("R1 reset wake", wfi_clr_o, 0);
    chk("R1 reset pending", irq_pending_o, 0);
    rst_n = 1;
    @(negedge clk);
    // sweep mask, thumb, vector select, request kind and address
    for (int i = 0; i < 2; i++)
      for (int t = 0; t < 2; t++)
        for (int h = 0; h < 2; h++)
          for (int k = 0; k < 3; k++)
            for (int p = 0; p < 3; p++) begin
              logic [31:0] st;
              st = (32'h5A3C_9E00 ^ (p << 20)) | 32'h40 | (i << 7) | (t << 5) | 5'h1F;
              attempt(st, pcs[p], h[0], k != 1, k != 0);
            end
    // drain any deferred IRQ with no request line
    attempt(32'h0000_001F, 32'h100, 1'b0, 1'b0, 1'b0);
    chk("R11 drained", irq_pending_o, 0);
    // R12 collision then masked, then unmasked drain
    attempt(32'h0000_0010, 32'h200, 1'b1, 1'b1, 1'b1);
    attempt(32'h0000_0092, 32'h204, 1'b1, 1'b0, 1'b0);
    attempt(32'h0000_0012, 32'h208, 1'b1, 1'b0, 1'b0);
    // R13 requests without boundary
    status_i = 32'h10; irq_req_i = 1; pabt_req_i = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R13 no boundary", entry_we_o, 0);
    end
    irq_req_i = 0; pabt_req_i = 0;
    // R2 masked flag ignored
    status_i = 32'h90; irq_flag_i = 1;
    @(negedge clk);
    irq_flag_i = 0;
    chk("R2 masked flag wake", wfi_clr_o, 0);
    chk("R2 masked flag pending", irq_pending_o, 0);
    // R10/R11 unmasked flag
    status_i = 32'h10; irq_flag_i = 1;
    @(negedge clk);
    irq_flag_i = 0;
    chk("R10 flag wake", wfi_clr_o, 1);
    chk("R11 flag pending", irq_pending_o, 1);
    @(negedge clk);
    chk("R10 wake one cycle", wfi_clr_o, 0);
    pend_m = 1;
    attempt(32'h0000_0010, 32'h300, 1'b0, 1'b0, 1'b0);
    chk("R11 pending cleared", irq_pending_o, 0);
    // R9 held request and boundary: acceptance every third cycle
    status_i = 32'h10; irq_req_i = 1; boundary_i = 1;
    n = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (entry_we_o) n++;
    end
    boundary_i = 0; irq_req_i = 0;
    chk("R9 held request spacing", n, 2);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule